// File: doc/BRIEF.md
# Core-Voltage Start-Up and Reference Sequencer

This block produces the digital reference code for a multiphase core-voltage regulator. The code is an unsigned count of 6.25 mV steps, and an external converter turns it into the analog reference. When enabled, the block first ramps the code from zero up to a fixed boot level and holds it there for a programmed number of soft-start ticks. It then reads the 8-bit voltage-identification (VID) code. If that code is usable, the block ramps on to the requested level less a signed trim offset. Every ramp moves exactly one step per soft-start tick, so the tick rate alone sets the slew. Once regulating, later VID or offset changes are followed one step per tick, and the start-up does not restart.

Overvoltage and overcurrent comparator results arrive as digital inputs. Either fault is latched until the enable input is dropped, and a latched fault freezes the reference.

- **Overvoltage:** the block tri-states the PWM outputs. It commands the low-side switches on whenever the overvoltage input is high, and releases them when it falls.
- **Overcurrent:** the block tri-states the PWM outputs and drops the driver-enable output.

Dropping enable clears every fault and re-arms the whole sequence.

Top module: `corev_seq`

## Requirements
- R1: While `en` is low (one clock after it falls, and after reset), `ref_code`=0, `pgood`=0, `drv_en`=0, `pwm_tri`=1 and `low_on`=0.
- R2: In every ramp, `ref_code` changes by exactly one step on each clock where `tick`=1 and a ramp applies. It never changes on a clock where `tick`=0.
- R3: The first ramp starts one clock after `en` rises and climbs from 0 to BOOT_STEPS (176 by default). `ref_code` then stays at BOOT_STEPS for HOLD_TICKS ticks (8 by default). The VID is read only on the HOLD_TICKS-th tick after the boot level is reached.
- R4: A usable VID code v, with offset o (a signed two's-complement `ofs`), gives the target 256 − v − o, clamped to the range 0..511. The second ramp reaches it in exactly |target − 176| ticks.
- R5: VID codes 0xFE and 0xFF mean "off". If one of them is present when the VID is read, `ref_code` stays at BOOT_STEPS, and the VID is read again on each later tick until a usable code appears.
- R6: `pgood` rises one clock after the second ramp makes `ref_code` equal to the target, provided no fault is latched.
- R7: While regulating, a new usable VID or offset moves `ref_code` one step per tick to the new target, and `pgood` stays 1. An off code seen while regulating leaves `ref_code` unchanged.
- R8: `ovp_in`=1 at a clock edge while enabled latches an overvoltage fault. From the next clock, `pwm_tri`=1, `pgood`=0, `ref_code` is frozen and `low_on` equals `ovp_in`, while `drv_en` stays 1.
- R9: `ocp_in`=1 at a clock edge while enabled latches an overcurrent fault. From the next clock, `drv_en`=0, `pwm_tri`=1, `low_on`=0 and `ref_code` is frozen, even after `ocp_in` falls.
- R10: Dropping `en` for one clock clears all latched faults and re-arms the sequence. After `en` rises again, the first ramp restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; low clears faults and re-arms the sequence |
| tick | input | 1 | Soft-start tick, one clock wide |
| vid | input | 8 | Voltage-identification code |
| ofs | input | 6 | Signed trim offset in steps, subtracted from the VID target |
| ovp_in | input | 1 | Overvoltage comparator result |
| ocp_in | input | 1 | Overcurrent comparator result |
| ref_code | output | 9 | Reference level in 6.25 mV steps |
| drv_en | output | 1 | Enable for the external switch drivers |
| pwm_tri | output | 1 | Tri-state (disable) for the PWM outputs |
| low_on | output | 1 | Command to turn the low-side switches on |
| pgood | output | 1 | Output voltage at its target with no fault |

## Verification
Each tick moves `ref_code` at the clock edge where the tick is seen. The bench drives the tick just after a falling edge and reads the result at the next falling edge. For that reason a ramp is checked once per tick, and a settle is checked by counting ticks rather than clocks. `pgood` follows the final step of the second ramp by one more clock, so the bench checks it low right after that step and high one clock later. A fault input or a change of `en` shows at the outputs one clock after it is applied, except `low_on`, which follows `ovp_in` within the same clock once the fault is latched. The checks sample at those same falling edges.

// File: rtl/corev_seq_pkg.sv
package corev_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_BOOT_RAMP = 3'd1,
      ST_BOOT_HOLD = 3'd2,
      ST_TRIM_RAMP = 3'd3,
      ST_REGULATE  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/vid_decode.sv
module vid_decode #(
   parameter int unsigned VID_W     = 8,
   parameter int unsigned OFS_W     = 6,
   parameter int unsigned REF_W     = 9,
   parameter int unsigned TOP_STEPS = 256,
   parameter int unsigned OFF_CODES = 2
) (
   input  logic [VID_W-1:0]        vid,
   input  logic signed [OFS_W-1:0] ofs,
   output logic                    usable,
   output logic [REF_W-1:0]        target
);
   localparam int SW = REF_W + 2;
   localparam int unsigned MAX_REF = (1 << REF_W) - 1;
   localparam int unsigned CODE_SPAN = 1 << VID_W;

   if (TOP_STEPS > MAX_REF) begin : g_bad_top
      $error("TOP_STEPS must fit in REF_W bits");
   end
   if (OFS_W + 1 > REF_W) begin : g_bad_ofs
      $error("OFS_W too wide for REF_W");
   end

   // off-code window at the top of the code space
   if (OFF_CODES == 0) begin : g_all_usable
      assign usable = 1'b1;
   end else begin : g_top_off
      assign usable = (int'(vid) < int'(CODE_SPAN - OFF_CODES));
   end

   logic signed [SW-1:0] base_s, vid_s, ofs_s, diff_s;

   always_comb begin
      base_s = SW'(TOP_STEPS);
      vid_s  = SW'(vid);
      ofs_s  = SW'(ofs);
      diff_s = base_s - vid_s - ofs_s;
      if (diff_s < 0)
         target = '0;
      else if (diff_s > SW'(MAX_REF))
         target = REF_W'(MAX_REF);
      else
         target = diff_s[REF_W-1:0];
   end
endmodule

// File: rtl/ref_stepper.sv
module ref_stepper #(
   parameter int unsigned REF_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step_en,
   input  logic [REF_W-1:0] goal,
   output logic [REF_W-1:0] level
);
   logic [REF_W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= '0;
      else if (clr)
         level_q <= '0;
      else if (step_en) begin
         if (level_q < goal)
            level_q <= level_q + 1'b1;
         else if (level_q > goal)
            level_q <= level_q - 1'b1;
      end
   end

   assign level = level_q;

   p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step_en) |=> $stable(level_q));

   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (level_q == $past(level_q) ||
                level_q == $past(level_q) + REF_W'(1) ||
                level_q == $past(level_q) - REF_W'(1)));
endmodule

// File: rtl/fault_keeper.sv
module fault_keeper (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic ovp_in,
   input  logic ocp_in,
   output logic ovp_lat,
   output logic ocp_lat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovp_lat <= 1'b0;
         ocp_lat <= 1'b0;
      end else if (!arm) begin
         ovp_lat <= 1'b0;
         ocp_lat <= 1'b0;
      end else begin
         if (ovp_in) ovp_lat <= 1'b1;
         if (ocp_in) ocp_lat <= 1'b1;
      end
   end

   p_ovp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovp_lat && arm) |=> ovp_lat);

   p_ocp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ocp_lat) |-> $past(ocp_in));

   p_disarm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (!ovp_lat && !ocp_lat));
endmodule

// File: rtl/corev_seq.sv
module corev_seq
   import corev_seq_pkg::*;
#(
   parameter int unsigned VID_W      = 8,
   parameter int unsigned OFS_W      = 6,
   parameter int unsigned REF_W      = 9,
   parameter int unsigned TOP_STEPS  = 256,
   parameter int unsigned OFF_CODES  = 2,
   parameter int unsigned BOOT_STEPS = 176,
   parameter int unsigned HOLD_TICKS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    tick,
   input  logic [VID_W-1:0]        vid,
   input  logic signed [OFS_W-1:0] ofs,
   input  logic                    ovp_in,
   input  logic                    ocp_in,
   output logic [REF_W-1:0]        ref_code,
   output logic                    drv_en,
   output logic                    pwm_tri,
   output logic                    low_on,
   output logic                    pgood
);
   localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
   localparam logic [REF_W:0] BOOT_W = (REF_W + 1)'(BOOT_STEPS);

   if (BOOT_STEPS < 1 || BOOT_STEPS >= (1 << REF_W)) begin : g_bad_boot
      $error("BOOT_STEPS out of range");
   end
   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 1");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] hold_q;
   logic [REF_W-1:0] tgt_q;
   logic [REF_W-1:0] level;
   logic [REF_W-1:0] vid_tgt;
   logic [REF_W-1:0] want;
   logic [REF_W-1:0] goal;
   logic             vid_ok;
   logic             ovp_lat, ocp_lat, fault;
   logic             ramping, step_en;

   vid_decode #(
      .VID_W(VID_W), .OFS_W(OFS_W), .REF_W(REF_W),
      .TOP_STEPS(TOP_STEPS), .OFF_CODES(OFF_CODES)
   ) u_dec (
      .vid(vid), .ofs(ofs), .usable(vid_ok), .target(vid_tgt)
   );

   fault_keeper u_flt (
      .clk(clk), .rst_n(rst_n), .arm(en),
      .ovp_in(ovp_in), .ocp_in(ocp_in),
      .ovp_lat(ovp_lat), .ocp_lat(ocp_lat)
   );

   assign fault = ovp_lat | ocp_lat;
   assign want  = vid_ok ? vid_tgt : tgt_q;

   always_comb begin
      ramping = 1'b0;
      goal    = level;
      case (state_q)
         ST_BOOT_RAMP: begin
            ramping = 1'b1;
            goal    = REF_W'(BOOT_STEPS);
         end
         ST_TRIM_RAMP, ST_REGULATE: begin
            ramping = 1'b1;
            goal    = want;
         end
         default: ;
      endcase
   end

   assign step_en = tick & ramping & ~fault & en;

   ref_stepper #(.REF_W(REF_W)) u_step (
      .clk(clk), .rst_n(rst_n), .clr(~en), .step_en(step_en),
      .goal(goal), .level(level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
         tgt_q   <= '0;
      end else if (!en) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
         tgt_q   <= '0;
      end else if (!fault) begin
         case (state_q)
            ST_IDLE: state_q <= ST_BOOT_RAMP;
            ST_BOOT_RAMP:
               if (tick && ({1'b0, level} + 1'b1 == BOOT_W)) begin
                  state_q <= ST_BOOT_HOLD;
                  hold_q  <= '0;
               end
            ST_BOOT_HOLD:
               if (tick) begin
                  if (hold_q == CNT_W'(HOLD_TICKS - 1)) begin
                     if (vid_ok) begin
                        tgt_q   <= vid_tgt;
                        state_q <= ST_TRIM_RAMP;
                     end
                  end else begin
                     hold_q <= hold_q + 1'b1;
                  end
               end
            ST_TRIM_RAMP: begin
               if (level == tgt_q) state_q <= ST_REGULATE;
               if (tick) tgt_q <= want;
            end
            ST_REGULATE:
               if (tick) tgt_q <= want;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ref_code = level;
   assign pgood    = (state_q == ST_REGULATE) & ~fault;
   assign drv_en   = en & (state_q != ST_IDLE) & ~ocp_lat;
   assign pwm_tri  = (state_q == ST_IDLE) | fault;
   assign low_on   = ovp_lat & ovp_in & ~ocp_lat;

   p_boot_below_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BOOT_RAMP) |-> (level < REF_W'(BOOT_STEPS)));

   p_hold_at_boot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BOOT_HOLD) |-> (level == REF_W'(BOOT_STEPS)));

   p_good_on_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> $past(level == tgt_q));

   p_fault_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && en) |=> (level == $past(level) || level == '0));

   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (level == '0 && !pgood));
endmodule

// File: tb/sim_corev_seq.sv
module sim_corev_seq;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              tick = 1'b0;
   logic [7:0]        vid = 8'h30;
   logic signed [5:0] ofs = 6'sd0;
   logic              ovp_in = 1'b0;
   logic              ocp_in = 1'b0;
   logic [8:0]        ref_code;
   logic              drv_en, pwm_tri, low_on, pgood;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   corev_seq u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .vid(vid), .ofs(ofs),
      .ovp_in(ovp_in), .ocp_in(ocp_in), .ref_code(ref_code),
      .drv_en(drv_en), .pwm_tri(pwm_tri), .low_on(low_on), .pgood(pgood)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask

   function automatic int exp_tgt(input int v, input int o);
      int t;
      t = 256 - v - o;
      if (t < 0) t = 0;
      if (t > 511) t = 511;
      return t;
   endfunction

   // change vid/ofs while regulating and count ticks to settle
   task automatic move_to(input int v, input int o, input string req);
      int t, cur, need, n;
      vid = 8'(v);
      ofs = 6'(o);
      t = exp_tgt(v, o);
      cur = int'(ref_code);
      need = (t > cur) ? t - cur : cur - t;
      n = 0;
      while (int'(ref_code) != t && n < 700) begin
         do_tick();
         n++;
      end
      chk(n == need && int'(ref_code) == t, req, n, need);
      chk(pgood == 1'b1, req, int'(pgood), 1);
   endtask

   // full start-up from a fresh enable, landing at target of v,o
   task automatic start_up(input int v, input int o);
      int t, n;
      en = 1'b1;
      idle_cycle();
      chk(ref_code == 9'd0 && drv_en == 1'b1 && pwm_tri == 1'b0, "R10 rearm",
          int'(ref_code), 0);
      for (int i = 1; i <= 176; i++) begin
         do_tick();
         if (i == 1 || i == 176) chk(int'(ref_code) == i, "R2 first ramp", int'(ref_code), i);
      end
      vid = 8'(v);
      ofs = 6'(o);
      for (int i = 1; i <= 8; i++) do_tick();
      chk(ref_code == 9'd176, "R3 level at read", int'(ref_code), 176);
      t = exp_tgt(v, o);
      n = 0;
      while (int'(ref_code) != t && n < 700) begin
         do_tick();
         n++;
      end
      chk(n == ((t > 176) ? t - 176 : 176 - t), "R4 second ramp ticks", n,
          (t > 176) ? t - 176 : 176 - t);
      idle_cycle();
      chk(pgood == 1'b1, "R6 pgood after start", int'(pgood), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_cycle();
      // R1 reset / disabled state
      chk(ref_code == 9'd0, "R1 ref", int'(ref_code), 0);
      chk(pgood == 1'b0 && drv_en == 1'b0, "R1 pgood/drv_en", int'({pgood, drv_en}), 0);
      chk(pwm_tri == 1'b1 && low_on == 1'b0, "R1 tri/low", int'({pwm_tri, low_on}), 2);
      do_tick();
      chk(ref_code == 9'd0, "R1 tick ignored while disabled", int'(ref_code), 0);

      // first ramp, one step per tick
      vid = 8'h30;
      en = 1'b1;
      idle_cycle();
      chk(ref_code == 9'd0 && drv_en == 1'b1, "R3 ramp start", int'(ref_code), 0);
      for (int i = 1; i <= 176; i++) begin
         do_tick();
         chk(int'(ref_code) == i, "R2 ramp step", int'(ref_code), i);
         if (i == 50) begin
            idle_cycle();
            idle_cycle();
            chk(int'(ref_code) == 50, "R2 no tick no move", int'(ref_code), 50);
         end
      end
      // hold: valid VID present but must not be read early
      for (int i = 1; i <= 7; i++) begin
         do_tick();
         chk(ref_code == 9'd176, "R3 hold at boot", int'(ref_code), 176);
      end
      vid = 8'hFE;
      do_tick();
      chk(ref_code == 9'd176 && pgood == 1'b0, "R5 off code at read", int'(ref_code), 176);
      vid = 8'hFF;
      do_tick();
      do_tick();
      chk(ref_code == 9'd176, "R5 off code reread", int'(ref_code), 176);
      vid = 8'h30;
      do_tick();
      chk(ref_code == 9'd176, "R5 read tick no step", int'(ref_code), 176);
      for (int i = 177; i <= 208; i++) begin
         do_tick();
         chk(int'(ref_code) == i, "R4 second ramp step", int'(ref_code), i);
      end
      chk(pgood == 1'b0, "R6 pgood not yet", int'(pgood), 0);
      idle_cycle();
      chk(pgood == 1'b1, "R6 pgood rises", int'(pgood), 1);

      // R7 sweep every usable VID while regulating
      for (int v = 0; v <= 253; v++) move_to(v, 0, "R7 vid sweep");
      held = int'(ref_code);
      vid = 8'hFF;
      for (int i = 0; i < 3; i++) do_tick();
      chk(int'(ref_code) == held, "R7 off code ignored", int'(ref_code), held);
      vid = 8'hFE;
      do_tick();
      chk(int'(ref_code) == held && pgood, "R7 off code ignored", int'(ref_code), held);
      // R4 offset sweep incl. clamp
      for (int o = -32; o <= 31; o++) move_to(8'h40, o, "R4 offset sweep");
      move_to(250, 31, "R4 clamp low");
      move_to(0, -32, "R4 max target");

      // R8 overvoltage
      held = int'(ref_code);
      ovp_in = 1'b1;
      idle_cycle();
      chk(pwm_tri == 1'b1 && pgood == 1'b0, "R8 tri and pgood", int'({pwm_tri, pgood}), 2);
      chk(low_on == 1'b1 && drv_en == 1'b1, "R8 low on", int'({low_on, drv_en}), 3);
      ovp_in = 1'b0;
      vid = 8'h80;
      do_tick();
      chk(low_on == 1'b0 && int'(ref_code) == held, "R8 release frozen", int'(ref_code), held);
      chk(pwm_tri == 1'b1, "R8 still latched", int'(pwm_tri), 1);
      ovp_in = 1'b1;
      idle_cycle();
      chk(low_on == 1'b1, "R8 reapplied", int'(low_on), 1);
      ovp_in = 1'b0;

      // R10 clear and re-arm
      en = 1'b0;
      idle_cycle();
      chk(ref_code == 9'd0 && pwm_tri == 1'b1 && low_on == 1'b0 && drv_en == 1'b0,
          "R10 cleared", int'(ref_code), 0);
      en = 1'b1;
      idle_cycle();
      chk(pwm_tri == 1'b0, "R10 fault cleared", int'(pwm_tri), 0);
      for (int i = 1; i <= 10; i++) do_tick();
      chk(ref_code == 9'd10, "R10 restart from 0", int'(ref_code), 10);

      // R9 overcurrent during first ramp
      ocp_in = 1'b1;
      idle_cycle();
      ocp_in = 1'b0;
      chk(drv_en == 1'b0 && pwm_tri == 1'b1 && low_on == 1'b0, "R9 shutdown",
          int'({drv_en, pwm_tri, low_on}), 2);
      for (int i = 0; i < 4; i++) do_tick();
      chk(ref_code == 9'd10 && drv_en == 1'b0, "R9 frozen latched", int'(ref_code), 10);

      en = 1'b0;
      idle_cycle();
      chk(ref_code == 9'd0 && drv_en == 1'b0, "R1 after disable", int'(ref_code), 0);
      start_up(0, 5);
      en = 1'b0;
      idle_cycle();
      start_up(200, -3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule